// File: doc/BRIEF.md
# Bypass-Mode Flash Word Programmer

This block sits on the host side of a 16-bit parallel NOR flash that software has already placed in its unlock-bypass state. It takes program requests (a word address and a 16-bit value) over a valid/ready port. For each request it runs two bus writes: a setup command to the flash base address, then the value to the target address. After that it reads the status word back from the same address. It keeps reading until bit 7 of the status word equals bit 7 of the value written. It then takes one more read to confirm the full word before it reports success.

A request with the exit flag set does not program anything. It issues the two writes that take the flash out of bypass mode. Every bus write drives the write strobe low for a fixed number of clocks, and every status read drives the output-enable strobe low for a fixed number of clocks. A bounded poll count keeps a flash that never finishes from hanging the sequencer. When the bound is reached the word is aborted and the error flag is raised.

Top module: `nor_bypass_prog_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `bus_we_n` and `bus_oe_n` are 1, and `done` and `err` are 0.
- R2: A program request (`req_exit`=0) produces exactly two bus writes, in this order: value 16'h00A0 to `BASE_ADDR`, then `req_data` to `req_addr`.
- R3: Each bus write holds `bus_we_n` low for exactly `WE_CLKS` clocks, and `bus_addr` and `bus_dout` do not change during the pulse.
- R4: Every status read after a program request uses the programmed address. It holds `bus_oe_n` low for `RD_CLKS` clocks.
- R5: When a polled bit 7 equals the written bit 7, one further read is made. If that read equals the whole written word, `done` pulses high for one clock.
- R6: While a polled bit 7 is the complement of the written bit 7, polling continues with another read.
- R7: If `MAX_POLLS` status reads all show a mismatched bit 7, `err` pulses for one clock and no further bus cycle is issued for that word. Reaching a match on read number `MAX_POLLS` still succeeds.
- R8: If the confirming read differs from the written word in any bit, `err` pulses instead of `done`.
- R9: An exit request (`req_exit`=1) produces exactly two writes to `BASE_ADDR`, 16'h0090 then 16'h0000, with no reads, followed by a `done` pulse.
- R10: `req_ready` is 0 from the clock after a request is accepted until the `done` or `err` pulse appears. Back-to-back program requests repeat only the two-write pair, with no further unlock writes.
- R11: `bus_we_n` and `bus_oe_n` are never low in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and accepting a request |
| req_exit | input | 1 | 1 = leave bypass mode, 0 = program a word |
| req_addr | input | AW | Word address to program |
| req_data | input | 16 | Value to program |
| bus_addr | output | AW | Flash word address |
| bus_dout | output | 16 | Data driven to the flash on writes |
| bus_din | input | 16 | Data returned by the flash on reads |
| bus_we_n | output | 1 | Active-low write strobe |
| bus_oe_n | output | 1 | Active-low output-enable strobe |
| done | output | 1 | One-clock pulse: word programmed or exit sequence finished |
| err | output | 1 | One-clock pulse: poll bound reached or confirm mismatch |

## Verification
Some rules are checked by assertions on every clock:
- the two strobes never overlap;
- address and data stay stable while the write strobe is low;
- reads stay on the programmed address;
- the ready output stays low during bus activity;
- the poll count never exceeds its bound;
- done and error never coincide.

Other behaviour only the bench's flash model can show, by answering status reads:
- the exact command values and their order;
- the number of reads taken for each busy time;
- the boundary where a match on the last permitted poll still succeeds;
- the error path after a bad confirm read.

// File: rtl/nbp_pkg.sv
package nbp_pkg;
    localparam int DW = 16;

    localparam logic [DW-1:0] CMD_PROG_SETUP = 16'h00A0;
    localparam logic [DW-1:0] CMD_LEAVE_A    = 16'h0090;
    localparam logic [DW-1:0] CMD_LEAVE_B    = 16'h0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_DATA,
        ST_POLL,
        ST_CONFIRM,
        ST_LEAVE_A,
        ST_LEAVE_B
    } seq_state_e;
endpackage

// File: rtl/nbp_bus_engine.sv
module nbp_bus_engine #(
    parameter int AW      = 20,
    parameter int DW      = 16,
    parameter int WE_CLKS = 3,
    parameter int RD_CLKS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_wr,
    input  logic [AW-1:0] op_addr,
    input  logic [DW-1:0] op_wdata,
    output logic          op_done,
    output logic [DW-1:0] op_rdata,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    input  logic [DW-1:0] bus_din,
    output logic          bus_we_n,
    output logic          bus_oe_n
);
    localparam int MAXC = (WE_CLKS > RD_CLKS) ? WE_CLKS : RD_CLKS;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC + 1) : 1;

    typedef struct packed {
        logic          active;
        logic          wr;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] dout;
        logic          we_n;
        logic          oe_n;
        logic          done;
        logic [DW-1:0] rdata;
    } eng_s;

    eng_s q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.active) begin
            if (start) begin
                d.active = 1'b1;
                d.wr     = is_wr;
                d.addr   = op_addr;
                d.dout   = op_wdata;
                d.cnt    = is_wr ? CW'(WE_CLKS - 1) : CW'(RD_CLKS - 1);
                d.we_n   = !is_wr;
                d.oe_n   = is_wr;
            end
        end else if (q.cnt == '0) begin
            d.active = 1'b0;
            d.we_n   = 1'b1;
            d.oe_n   = 1'b1;
            d.done   = 1'b1;
            if (!q.wr) begin
                d.rdata = bus_din;
            end
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.we_n <= 1'b1;
            q.oe_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign op_done  = q.done;
    assign op_rdata = q.rdata;
    assign bus_addr = q.addr;
    assign bus_dout = q.dout;
    assign bus_we_n = q.we_n;
    assign bus_oe_n = q.oe_n;

    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_we_n && !bus_oe_n));

    p_wr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we_n && $past(!bus_we_n)) |-> ($stable(bus_addr) && $stable(bus_dout)));

    p_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (bus_we_n && bus_oe_n));
endmodule

// File: rtl/nbp_poll_ctr.sv
module nbp_poll_ctr #(
    parameter int MAX_POLLS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int PW = $clog2(MAX_POLLS + 1);

    logic [PW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_limit = (cnt_q >= PW'(MAX_POLLS));

    p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= PW'(MAX_POLLS));

    p_no_inc_at_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> !at_limit);
endmodule

// File: rtl/nor_bypass_prog_seq.sv
module nor_bypass_prog_seq #(
    parameter int              AW        = 20,
    parameter logic [AW-1:0]   BASE_ADDR = '0,
    parameter int              WE_CLKS   = 3,
    parameter int              RD_CLKS   = 2,
    parameter int              MAX_POLLS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_exit,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_data,
    output logic [AW-1:0] bus_addr,
    output logic [15:0]   bus_dout,
    input  logic [15:0]   bus_din,
    output logic          bus_we_n,
    output logic          bus_oe_n,
    output logic          done,
    output logic          err
);
    import nbp_pkg::*;

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          done;
        logic          err;
    } seq_s;

    seq_s q, d;

    logic          eng_start, eng_wr, eng_done;
    logic [AW-1:0] eng_addr;
    logic [DW-1:0] eng_wdata, eng_rdata;
    logic          pc_clr, pc_inc, pc_limit;

    nbp_bus_engine #(
        .AW(AW), .DW(DW), .WE_CLKS(WE_CLKS), .RD_CLKS(RD_CLKS)
    ) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start(eng_start), .is_wr(eng_wr),
        .op_addr(eng_addr), .op_wdata(eng_wdata),
        .op_done(eng_done), .op_rdata(eng_rdata),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din),
        .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n)
    );

    nbp_poll_ctr #(.MAX_POLLS(MAX_POLLS)) u_pc (
        .clk(clk), .rst_n(rst_n),
        .clr(pc_clr), .inc(pc_inc), .at_limit(pc_limit)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.err     = 1'b0;
        eng_start = 1'b0;
        eng_wr    = 1'b0;
        eng_addr  = BASE_ADDR;
        eng_wdata = '0;
        pc_clr    = 1'b0;
        pc_inc    = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr    = req_addr;
                    d.data    = req_data;
                    pc_clr    = 1'b1;
                    eng_start = 1'b1;
                    eng_wr    = 1'b1;
                    if (req_exit) begin
                        eng_wdata = CMD_LEAVE_A;
                        d.st      = ST_LEAVE_A;
                    end else begin
                        eng_wdata = CMD_PROG_SETUP;
                        d.st      = ST_SETUP;
                    end
                end
            end
            ST_SETUP: begin
                if (eng_done) begin
                    eng_start = 1'b1;
                    eng_wr    = 1'b1;
                    eng_addr  = q.addr;
                    eng_wdata = q.data;
                    d.st      = ST_DATA;
                end
            end
            ST_DATA: begin
                if (eng_done) begin
                    eng_start = 1'b1;
                    eng_addr  = q.addr;
                    pc_inc    = 1'b1;
                    d.st      = ST_POLL;
                end
            end
            ST_POLL: begin
                if (eng_done) begin
                    if (eng_rdata[7] == q.data[7]) begin
                        eng_start = 1'b1;
                        eng_addr  = q.addr;
                        d.st      = ST_CONFIRM;
                    end else if (pc_limit) begin
                        d.err = 1'b1;
                        d.st  = ST_IDLE;
                    end else begin
                        eng_start = 1'b1;
                        eng_addr  = q.addr;
                        pc_inc    = 1'b1;
                    end
                end
            end
            ST_CONFIRM: begin
                if (eng_done) begin
                    if (eng_rdata == q.data) begin
                        d.done = 1'b1;
                    end else begin
                        d.err = 1'b1;
                    end
                    d.st = ST_IDLE;
                end
            end
            ST_LEAVE_A: begin
                if (eng_done) begin
                    eng_start = 1'b1;
                    eng_wr    = 1'b1;
                    eng_wdata = CMD_LEAVE_B;
                    d.st      = ST_LEAVE_B;
                end
            end
            ST_LEAVE_B: begin
                if (eng_done) begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign done      = q.done;
    assign err       = q.err;

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we_n || !bus_oe_n) |-> !req_ready);

    p_read_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_n |-> (bus_addr == q.addr));

    p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err}));

    p_flag_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> !(done || err));
endmodule

// File: tb/tb_nor_bypass_prog_seq.sv
module tb_nor_bypass_prog_seq;
    localparam int            AW    = 20;
    localparam logic [AW-1:0] BASE  = 20'h00000;
    localparam int            WEC   = 3;
    localparam int            RDC   = 2;
    localparam int            MAXP  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          req_valid = 1'b0, req_exit = 1'b0, req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_data = '0;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_dout, bus_din;
    logic          bus_we_n, bus_oe_n, done, err;

    nor_bypass_prog_seq #(
        .AW(AW), .BASE_ADDR(BASE), .WE_CLKS(WEC), .RD_CLKS(RDC), .MAX_POLLS(MAXP)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_exit(req_exit),
        .req_addr(req_addr), .req_data(req_data),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din),
        .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n),
        .done(done), .err(err)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Flash model and bus monitor
    logic [AW-1:0] cur_addr = '0;
    logic [15:0]   cur_data = '0;
    int            busy_n   = 0;
    bit            bad_cfm  = 1'b0;
    int            rbase    = 0;

    logic [AW-1:0] wl_addr [0:63];
    logic [15:0]   wl_data [0:63];
    int wcount = 0, rcount = 0, dcount = 0, ecount = 0;
    int wid_bad = 0, stab_bad = 0, excl_bad = 0, rdy_bad = 0, raddr_bad = 0, rwid_bad = 0;
    int wlen = 0, rlen = 0;
    logic          prev_we = 1'b1, prev_oe = 1'b1;
    logic [AW-1:0] pw_addr = '0;
    logic [15:0]   pw_data = '0;

    always_comb begin
        if ((rcount - rbase) < busy_n)
            bus_din = ~cur_data;
        else if (bad_cfm)
            bus_din = cur_data ^ 16'h0001;
        else
            bus_din = cur_data;
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (done) dcount <= dcount + 1;
            if (err)  ecount <= ecount + 1;
            if (!bus_we_n && !bus_oe_n) excl_bad <= excl_bad + 1;
            if ((!bus_we_n || !bus_oe_n) && req_ready) rdy_bad <= rdy_bad + 1;
            if (!bus_we_n && prev_we) begin
                wlen    <= 1;
                pw_addr <= bus_addr;
                pw_data <= bus_dout;
            end else if (!bus_we_n) begin
                wlen <= wlen + 1;
                if (bus_addr != pw_addr || bus_dout != pw_data) stab_bad <= stab_bad + 1;
            end else if (!prev_we) begin
                if (wlen != WEC) wid_bad <= wid_bad + 1;
                if (wcount < 64) begin
                    wl_addr[wcount] <= pw_addr;
                    wl_data[wcount] <= pw_data;
                end
                wcount <= wcount + 1;
            end
            if (!bus_oe_n && prev_oe) begin
                rlen <= 1;
                if (bus_addr != cur_addr) raddr_bad <= raddr_bad + 1;
            end else if (!bus_oe_n) begin
                rlen <= rlen + 1;
            end else if (!prev_oe) begin
                if (rlen != RDC) rwid_bad <= rwid_bad + 1;
                rcount <= rcount + 1;
            end
            prev_we <= bus_we_n;
            prev_oe <= bus_oe_n;
        end
    end

    typedef struct packed {
        logic          ex;
        logic [AW-1:0] addr;
        logic [15:0]   data;
        logic [7:0]    busy;
        logic          bad;
        logic          exp_err;
        logic [7:0]    exp_reads;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 20'h01234, 16'hBEEF, 8'd0, 1'b0, 1'b0, 8'd2},
        '{1'b0, 20'h00F00, 16'h0055, 8'd3, 1'b0, 1'b0, 8'd5},
        '{1'b0, 20'hABCDE, 16'h8000, 8'd5, 1'b0, 1'b0, 8'd7},
        '{1'b0, 20'h00002, 16'h7F7F, 8'd1, 1'b0, 1'b0, 8'd3},
        '{1'b1, 20'h00000, 16'h0000, 8'd0, 1'b0, 1'b0, 8'd0},
        '{1'b0, 20'h00010, 16'h00FF, 8'd0, 1'b0, 1'b0, 8'd2}
    };

    task automatic run_req(input vec_t v, input string tag);
        int wb, db, eb;
        bit seen;
        wb = wcount; db = dcount; eb = ecount;
        @(negedge clk);
        cur_addr  = v.ex ? BASE : v.addr;
        cur_data  = v.data;
        busy_n    = int'(v.busy);
        bad_cfm   = v.bad;
        rbase     = rcount;
        req_valid = 1'b1;
        req_exit  = v.ex;
        req_addr  = v.addr;
        req_data  = v.data;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10", {tag, " ready after accept"}, req_ready, 0);
        seen = 1'b0;
        for (int i = 0; i < 2000 && !seen; i++) begin
            @(negedge clk);
            if (dcount != db || ecount != eb) seen = 1'b1;
        end
        repeat (3) @(negedge clk);
        if (v.ex) begin
            chk(wcount - wb == 2, "R9", {tag, " write count"}, wcount - wb, 2);
            chk(wl_addr[wb] == BASE && wl_data[wb] == 16'h0090, "R9", {tag, " first exit write"},
                {wl_addr[wb], wl_data[wb]}, {BASE, 16'h0090});
            chk(wl_addr[wb+1] == BASE && wl_data[wb+1] == 16'h0000, "R9", {tag, " second exit write"},
                {wl_addr[wb+1], wl_data[wb+1]}, {BASE, 16'h0000});
            chk(rcount == rbase, "R9", {tag, " no reads"}, rcount - rbase, 0);
        end else begin
            chk(wcount - wb == 2, "R10", {tag, " write count"}, wcount - wb, 2);
            chk(wl_addr[wb] == BASE && wl_data[wb] == 16'h00A0, "R2", {tag, " setup write"},
                {wl_addr[wb], wl_data[wb]}, {BASE, 16'h00A0});
            chk(wl_addr[wb+1] == v.addr && wl_data[wb+1] == v.data, "R2", {tag, " data write"},
                {wl_addr[wb+1], wl_data[wb+1]}, {v.addr, v.data});
            chk(rcount - rbase == int'(v.exp_reads),
                v.exp_err ? "R7" : "R6", {tag, " read count"}, rcount - rbase, v.exp_reads);
        end
        chk(dcount - db == (v.exp_err ? 0 : 1), "R5", {tag, " done pulses"}, dcount - db, v.exp_err ? 0 : 1);
        chk(ecount - eb == (v.exp_err ? 1 : 0), "R8", {tag, " err pulses"}, ecount - eb, v.exp_err ? 1 : 0);
        chk(req_ready == 1'b1, "R10", {tag, " ready after finish"}, req_ready, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(bus_we_n == 1'b1 && bus_oe_n == 1'b1, "R1", "strobes idle", {bus_we_n, bus_oe_n}, 2'b11);
        chk(done == 1'b0 && err == 1'b0, "R1", "flags clear", {done, err}, 2'b00);

        for (int i = 0; i < NV; i++) begin
            run_req(VECS[i], $sformatf("vec%0d", i));
        end

        // R7 boundary: match on the last permitted poll still succeeds
        run_req('{1'b0, 20'h00333, 16'h1280, 8'(MAXP - 1), 1'b0, 1'b0, 8'(MAXP + 1)}, "r7_last_poll_ok");
        // R7 bound exhausted
        run_req('{1'b0, 20'h00444, 16'h0081, 8'(MAXP), 1'b0, 1'b1, 8'(MAXP)}, "r7_bound_hit");
        // R8 bad confirm read after bit-7 match
        run_req('{1'b0, 20'h00555, 16'hC3C3, 8'd2, 1'b1, 1'b1, 8'd4}, "r8_bad_confirm");
        // Recovery after errors
        run_req('{1'b0, 20'h00666, 16'h5A5A, 8'd0, 1'b0, 1'b0, 8'd2}, "after_err");

        chk(wid_bad == 0, "R3", "write pulse width mismatches", wid_bad, 0);
        chk(stab_bad == 0, "R3", "addr/data changes during write", stab_bad, 0);
        chk(raddr_bad == 0, "R4", "reads off programmed address", raddr_bad, 0);
        chk(rwid_bad == 0, "R4", "read pulse width mismatches", rwid_bad, 0);
        chk(excl_bad == 0, "R11", "overlapping strobes", excl_bad, 0);
        chk(rdy_bad == 0, "R10", "ready high during bus cycle", rdy_bad, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule